// File: doc/BRIEF.md
# Sigma-Delta Sinc Decimator with Averaging Integrator

This block turns a one-bit sigma-delta modulator stream into signed conversion results. Each accepted input bit counts as +1 (bit high) or -1 (bit low). It feeds a cascade of sinc integrators that run at the input bit rate and combs that run at the decimated rate. The sinc order and the decimation ratio are both programmable. The settled sinc outputs then go to an averaging integrator, which adds a programmable number of them into one conversion result. A fast mode runs the filter as a second-order sinc with a doubled result and a longer settling time.

A result is published into a data word that carries the low 24 bits of the sum above a channel byte. Two flags go with it: a result-ready flag that a read strobe clears, and an overrun flag that a dedicated clear pulse clears. A request line follows the ready flag when it is enabled, so that an external transfer engine can drain results. Conversions are launched by a start pulse while the block is enabled. They run once or repeat continuously. Dropping the enable clears all state.

Top module: `sdm_decim_top`

## Requirements
- R1: The decimation ratio equals `cfg_fosr_m1`+1, from 1 to 1024. The averaging count equals `cfg_iosr_m1`+1, from 1 to 256. The sinc order is `cfg_order`, from 1 to 5.
- R2: With order p and `cfg_fast`=0, the first p-1 decimated outputs are discarded. The result is the sum of the next iosr outputs. It is published on the clock edge that accepts input bit number fosr*(iosr-1+p)+p, counted from the first bit accepted after start. A constant input gives ±iosr*fosr^p.
- R3: With `cfg_fast`=1, the filter acts as order 2 and the result is doubled. It is published at bit fosr*(iosr+3)+2, so a constant input gives ±2*iosr*fosr^2.
- R4: An input bit of 1 counts as +1 and a bit of 0 counts as -1. At order 1, the result equals the sum of these values over the fosr*iosr bits that the result covers.
- R5: `data_word`[31:8] holds bits 23:0 of the two's-complement result, and `data_word`[7:0] holds `cfg_chan`. The word changes only when a result is published or when the block is disabled.
- R6: `eoc_flag` is set when a result is published and is cleared by a `data_rd` pulse. A publish in the same cycle as the read leaves the flag set.
- R7: A publish while `eoc_flag` is set and not being read in that cycle sets `ovr_flag`, and the new result replaces the word. A pulse on `ovr_clr` clears `ovr_flag`, and setting the flag wins over clearing it.
- R8: A conversion starts only when `cfg_start` is high and `cfg_en` is high while the block is idle. Input bits are accepted from the cycle after the start. With `cfg_cont`=0, the block returns to idle after one result and ignores later bits.
- R9: With `cfg_cont`=1, results follow the first one every fosr*iosr accepted bits, with no further start.
- R10: `dreq` is high exactly when `eoc_flag` is high and `cfg_dreq_en` is high.
- R11: With `cfg_en` low, the next clock edge clears `eoc_flag`, `ovr_flag`, `data_word` and all filter state. Any partial conversion is discarded and the block goes idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | Input bit strobe |
| bit_in | input | 1 | Modulator bit (1 = +1, 0 = -1) |
| cfg_en | input | 1 | Filter enable; low clears the block |
| cfg_start | input | 1 | Start pulse |
| cfg_cont | input | 1 | Continuous conversion mode |
| cfg_fast | input | 1 | Fast second-order mode |
| cfg_order | input | 3 | Sinc order 1..5 |
| cfg_fosr_m1 | input | 10 | Decimation ratio minus one |
| cfg_iosr_m1 | input | 8 | Averaging count minus one |
| cfg_chan | input | 8 | Channel number placed in the low byte |
| cfg_dreq_en | input | 1 | Enable for the transfer request |
| data_rd | input | 1 | Read strobe for the data word |
| ovr_clr | input | 1 | Overrun clear pulse |
| data_word | output | 32 | Result in bits 31:8, channel in bits 7:0 |
| eoc_flag | output | 1 | Result-ready flag |
| ovr_flag | output | 1 | Overrun flag |
| dreq | output | 1 | Transfer request |

## Verification
The hardest case to reach from the ports is the exact publish cycle when the settling discard, the averaging count and the tail delay all line up. This is worst at the extremes of the ratios and in fast mode. The bench counts every accepted bit from the start. It scores each result against the formula latency and the value of a constant or a known pattern. It covers order 1 at both ratio limits, orders 3 and 5, and fast mode. Overrun is reached by turning the reading monitor off while continuous results pile up.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } run_state_e;
endpackage

// File: rtl/sdm_cic.sv
// Sinc filter: MAX_ORD integrators at bit rate, MAX_ORD combs at decimated rate.
module sdm_cic #(
  parameter int MAX_ORD = 5,
  parameter int ACC_W   = 32,
  parameter int FOSR_W  = 10,
  parameter int TAP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              step,
  input  logic              bit_in,
  input  logic [TAP_W-1:0]  ord_m1,
  input  logic [FOSR_W-1:0] fosr_m1,
  output logic              dec_valid,
  output logic [ACC_W-1:0]  dec_data
);
  typedef logic [MAX_ORD-1:0][ACC_W-1:0] stage_vec_t;

  stage_vec_t integ_q, integ_n, integ_all;
  stage_vec_t comb_q, comb_n, cin_all, cout_all;
  logic [FOSR_W-1:0] phase_q, phase_n;
  logic [ACC_W-1:0]  sample;
  logic              dec_pt;

  assign sample = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};
  assign dec_pt = (phase_q == fosr_m1);

  for (genvar g = 0; g < MAX_ORD; g++) begin : g_stage
    logic [ACC_W-1:0] isum;
    logic [ACC_W-1:0] cin;
    if (g == 0) begin : g_head
      assign isum = integ_q[g] + sample;
      assign cin  = integ_all[ord_m1];
    end else begin : g_tail
      assign isum = integ_q[g] + g_stage[g-1].isum;
      assign cin  = g_stage[g-1].cout;
    end
    logic [ACC_W-1:0] cout;
    assign cout         = cin - comb_q[g];
    assign integ_all[g] = isum;
    assign cin_all[g]   = cin;
    assign cout_all[g]  = cout;
  end

  assign dec_valid = step && !clr && dec_pt;
  assign dec_data  = cout_all[ord_m1];

  always_comb begin
    integ_n = integ_q;
    comb_n  = comb_q;
    phase_n = phase_q;
    if (clr) begin
      integ_n = '0;
      comb_n  = '0;
      phase_n = '0;
    end else if (step) begin
      integ_n = integ_all;
      if (dec_pt) begin
        comb_n  = cin_all;
        phase_n = '0;
      end else begin
        phase_n = phase_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      integ_q <= '0;
      comb_q  <= '0;
      phase_q <= '0;
    end else if (clr || step) begin
      integ_q <= integ_n;
      comb_q  <= comb_n;
      phase_q <= phase_n;
    end
  end
endmodule

// File: rtl/sdm_avg.sv
// Settling discard and averaging accumulator over decimated outputs.
module sdm_avg #(
  parameter int ACC_W  = 32,
  parameter int IOSR_W = 8,
  parameter int TAP_W  = 3,
  parameter int SKIP_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              hold,
  input  logic              fast,
  input  logic [TAP_W-1:0]  ord_m1,
  input  logic [IOSR_W-1:0] iosr_m1,
  input  logic              dec_valid,
  input  logic [ACC_W-1:0]  dec_data,
  output logic              push,
  output logic [ACC_W-1:0]  push_data
);
  logic [SKIP_W-1:0] skip_q, skip_n, skip_tgt;
  logic [IOSR_W-1:0] cnt_q, cnt_n;
  logic [ACC_W-1:0]  acc_q, acc_n, total;

  // fast mode discards two more settling outputs than order 2
  assign skip_tgt  = fast ? SKIP_W'(3) : SKIP_W'(ord_m1);
  assign total     = acc_q + dec_data;
  assign push_data = fast ? {total[ACC_W-2:0], 1'b0} : total;

  always_comb begin
    skip_n = skip_q;
    cnt_n  = cnt_q;
    acc_n  = acc_q;
    push   = 1'b0;
    if (clr) begin
      skip_n = '0;
      cnt_n  = '0;
      acc_n  = '0;
    end else if (dec_valid && !hold) begin
      if (skip_q != skip_tgt) begin
        skip_n = skip_q + 1'b1;
      end else if (cnt_q == iosr_m1) begin
        push  = 1'b1;
        acc_n = '0;
        cnt_n = '0;
      end else begin
        acc_n = total;
        cnt_n = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      skip_q <= '0;
      cnt_q  <= '0;
      acc_q  <= '0;
    end else if (clr || dec_valid) begin
      skip_q <= skip_n;
      cnt_q  <= cnt_n;
      acc_q  <= acc_n;
    end
  end
endmodule

// File: rtl/sdm_tail.sv
// Bit-rate delay line: a pushed result emerges tap_m1+1 accepted bits later.
module sdm_tail #(
  parameter int DEPTH = 5,
  parameter int W     = 32,
  parameter int TAP_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic [TAP_W-1:0] tap_m1,
  output logic             pub,
  output logic [W-1:0]     pub_data
);
  logic [DEPTH-1:0]        vld_q, vld_n;
  logic [DEPTH-1:0][W-1:0] dat_q, dat_n;

  assign pub      = step && !clr && vld_q[tap_m1];
  assign pub_data = dat_q[tap_m1];

  always_comb begin
    vld_n = vld_q;
    dat_n = dat_q;
    if (clr) begin
      vld_n = '0;
      dat_n = '0;
    end else if (step) begin
      vld_n[0] = push;
      dat_n[0] = push_data;
      for (int i = 1; i < DEPTH; i++) begin
        vld_n[i] = vld_q[i-1];
        dat_n[i] = dat_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      dat_q <= '0;
    end else if (clr || step) begin
      vld_q <= vld_n;
      dat_q <= dat_n;
    end
  end
endmodule

// File: rtl/sdm_decim_top.sv
module sdm_decim_top #(
  parameter int MAX_ORD = 5,
  parameter int ACC_W   = 32,
  parameter int FOSR_W  = 10,
  parameter int IOSR_W  = 8,
  parameter int RES_W   = 24,
  parameter int CHAN_W  = 8,
  parameter int ORD_W   = $clog2(MAX_ORD + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bit_valid,
  input  logic                    bit_in,
  input  logic                    cfg_en,
  input  logic                    cfg_start,
  input  logic                    cfg_cont,
  input  logic                    cfg_fast,
  input  logic [ORD_W-1:0]        cfg_order,
  input  logic [FOSR_W-1:0]       cfg_fosr_m1,
  input  logic [IOSR_W-1:0]       cfg_iosr_m1,
  input  logic [CHAN_W-1:0]       cfg_chan,
  input  logic                    cfg_dreq_en,
  input  logic                    data_rd,
  input  logic                    ovr_clr,
  output logic [RES_W+CHAN_W-1:0] data_word,
  output logic                    eoc_flag,
  output logic                    ovr_flag,
  output logic                    dreq
);
  import sdm_pkg::*;

  localparam int TAP_W  = $clog2(MAX_ORD);
  localparam int SKIP_W = $clog2(MAX_ORD + 3);
  localparam int DW     = RES_W + CHAN_W;

  run_state_e       state_q, state_n;
  logic [TAP_W-1:0] ord_m1;
  logic             clr_dp, step, hold;
  logic             dec_valid, push, pub;
  logic [ACC_W-1:0] dec_data, push_data, pub_data;
  logic             eoc_q, eoc_n, ovr_q, ovr_n, ovr_set;
  logic [DW-1:0]    word_q, word_n;

  always_comb begin
    if (cfg_order == '0)                ord_m1 = '0;
    else if (int'(cfg_order) > MAX_ORD) ord_m1 = TAP_W'(MAX_ORD - 1);
    else                                ord_m1 = TAP_W'(cfg_order - 1'b1);
    if (cfg_fast)                       ord_m1 = TAP_W'(1);
  end

  assign clr_dp = (state_q == ST_IDLE) || !cfg_en;
  assign step   = (state_q != ST_IDLE) && cfg_en && bit_valid;
  assign hold   = (state_q == ST_DRAIN);

  sdm_cic #(.MAX_ORD(MAX_ORD), .ACC_W(ACC_W), .FOSR_W(FOSR_W), .TAP_W(TAP_W)) cic_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_dp), .step(step), .bit_in(bit_in),
    .ord_m1(ord_m1), .fosr_m1(cfg_fosr_m1),
    .dec_valid(dec_valid), .dec_data(dec_data)
  );

  sdm_avg #(.ACC_W(ACC_W), .IOSR_W(IOSR_W), .TAP_W(TAP_W), .SKIP_W(SKIP_W)) avg_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_dp), .hold(hold), .fast(cfg_fast),
    .ord_m1(ord_m1), .iosr_m1(cfg_iosr_m1), .dec_valid(dec_valid),
    .dec_data(dec_data), .push(push), .push_data(push_data)
  );

  sdm_tail #(.DEPTH(MAX_ORD), .W(ACC_W), .TAP_W(TAP_W)) tail_i (
    .clk(clk), .rst_n(rst_n), .clr(clr_dp), .step(step), .push(push),
    .push_data(push_data), .tap_m1(ord_m1), .pub(pub), .pub_data(pub_data)
  );

  // run control
  always_comb begin
    state_n = state_q;
    unique case (state_q)
      ST_IDLE:  if (cfg_en && cfg_start) state_n = ST_RUN;
      ST_RUN:   if (!cfg_en) state_n = ST_IDLE;
                else if (push && !cfg_cont) state_n = ST_DRAIN;
      ST_DRAIN: if (!cfg_en || pub) state_n = ST_IDLE;
      default:  state_n = ST_IDLE;
    endcase
  end

  // result word and flags
  assign ovr_set = pub && eoc_q && !data_rd;

  always_comb begin
    word_n = word_q;
    eoc_n  = eoc_q;
    ovr_n  = ovr_q;
    if (!cfg_en) begin
      word_n = '0;
      eoc_n  = 1'b0;
      ovr_n  = 1'b0;
    end else begin
      if (pub) begin
        word_n = {pub_data[RES_W-1:0], cfg_chan};
        eoc_n  = 1'b1;
      end else if (data_rd) begin
        eoc_n  = 1'b0;
      end
      if (ovr_set)      ovr_n = 1'b1;
      else if (ovr_clr) ovr_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      word_q  <= '0;
      eoc_q   <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      word_q  <= word_n;
      eoc_q   <= eoc_n;
      ovr_q   <= ovr_n;
    end
  end

  assign data_word = word_q;
  assign eoc_flag  = eoc_q;
  assign ovr_flag  = ovr_q;
  assign dreq      = eoc_q && cfg_dreq_en;
endmodule

// File: rtl/sdm_decim_chk.sv
module sdm_decim_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cfg_en,
  input logic          cfg_dreq_en,
  input logic          data_rd,
  input logic [DW-1:0] data_word,
  input logic          eoc_flag,
  input logic          ovr_flag,
  input logic          dreq
);
  assert_eoc_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_flag) |-> ($past(data_rd) || !$past(cfg_en)));

  assert_ovr_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr_flag) |-> ($past(eoc_flag) && eoc_flag));

  assert_disable_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!eoc_flag && !ovr_flag && data_word == '0));

  assert_word_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(data_word) |-> (eoc_flag || !$past(cfg_en)));

  assert_dreq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_dreq_en |-> !dreq);

  assert_dreq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eoc_flag) |-> !dreq);
endmodule

bind sdm_decim_top sdm_decim_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_dreq_en(cfg_dreq_en),
  .data_rd(data_rd), .data_word(data_word), .eoc_flag(eoc_flag),
  .ovr_flag(ovr_flag), .dreq(dreq)
);

// File: tb/sdm_decim_top_tb.sv
`timescale 1ns/1ps
module sdm_decim_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_valid, bit_in;
  logic        cfg_en, cfg_start, cfg_cont, cfg_fast, cfg_dreq_en;
  logic [2:0]  cfg_order;
  logic [9:0]  cfg_fosr_m1;
  logic [7:0]  cfg_iosr_m1;
  logic [7:0]  cfg_chan;
  logic        mon_rd, man_rd, data_rd, ovr_clr;
  logic [31:0] data_word;
  logic        eoc_flag, ovr_flag, dreq;

  int n_chk = 0;
  int n_fail = 0;
  int bit_idx = 0;
  bit mon_on = 1'b1;

  logic [31:0] exp_word_q[$];
  int          exp_at_q[$];
  string       exp_req_q[$];

  always #10 clk = ~clk;  // 50 MHz

  assign data_rd = mon_rd | man_rd;

  sdm_decim_top dut_i (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .cfg_en(cfg_en), .cfg_start(cfg_start), .cfg_cont(cfg_cont), .cfg_fast(cfg_fast),
    .cfg_order(cfg_order), .cfg_fosr_m1(cfg_fosr_m1), .cfg_iosr_m1(cfg_iosr_m1),
    .cfg_chan(cfg_chan), .cfg_dreq_en(cfg_dreq_en), .data_rd(data_rd), .ovr_clr(ovr_clr),
    .data_word(data_word), .eoc_flag(eoc_flag), .ovr_flag(ovr_flag), .dreq(dreq)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit pat(input int i);
    return ((i * 5 + 2) % 7) < 4;
  endfunction

  // scoreboard driver side: expected result value and publish bit index
  task automatic expect_res(input int val, input int at, input string req);
    logic [31:0] v;
    v = val;
    exp_word_q.push_back({v[23:0], cfg_chan});
    exp_at_q.push_back(at);
    exp_req_q.push_back(req);
  endtask

  // monitor: pops and compares each published result, reads it at once
  always @(negedge clk) begin
    mon_rd = 1'b0;
    if (mon_on && rst_n === 1'b1 && eoc_flag === 1'b1) begin
      if (exp_word_q.size() == 0) begin
        chk(1'b0, "R6 unexpected result", data_word, 0);
      end else begin
        logic [31:0] w;
        int at;
        string rq;
        w  = exp_word_q.pop_front();
        at = exp_at_q.pop_front();
        rq = exp_req_q.pop_front();
        chk(data_word == w, {rq, " value"}, data_word, w);
        chk(bit_idx == at, {rq, " latency"}, bit_idx, at);
      end
      mon_rd = 1'b1;
    end
  end

  task automatic setup(input int ord, input bit fast, input int fosr, input int iosr,
                       input bit cont, input logic [7:0] chan);
    @(negedge clk);
    cfg_order = 3'(ord); cfg_fast = fast; cfg_fosr_m1 = 10'(fosr - 1);
    cfg_iosr_m1 = 8'(iosr - 1); cfg_cont = cont; cfg_chan = chan;
  endtask

  task automatic pulse_start(input bit with_bit);
    @(negedge clk);
    cfg_start = 1'b1; bit_valid = with_bit; bit_in = 1'b0; bit_idx = 0;
    @(negedge clk);
    cfg_start = 1'b0; bit_valid = 1'b0;
  endtask

  task automatic send_bit(input logic b);
    @(negedge clk);
    bit_valid = 1'b1; bit_in = b;
    @(posedge clk);
    bit_idx++;
  endtask

  task automatic send_const(input logic b, input int n);
    for (int i = 0; i < n; i++) send_bit(b);
    @(negedge clk);
    bit_valid = 1'b0;
  endtask

  task automatic cycle_en();
    @(negedge clk); cfg_en = 1'b0;
    @(negedge clk); cfg_en = 1'b1;
  endtask

  task automatic drain_chk(input string req);
    repeat (3) @(negedge clk);
    chk(exp_word_q.size() == 0, {req, " pending results"}, exp_word_q.size(), 0);
  endtask

  initial begin
    #3_000_000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bit_valid = 1'b0; bit_in = 1'b0; cfg_en = 1'b1; cfg_start = 1'b0;
    cfg_cont = 1'b0; cfg_fast = 1'b0; cfg_dreq_en = 1'b0; cfg_order = 3'd1;
    cfg_fosr_m1 = '0; cfg_iosr_m1 = '0; cfg_chan = '0; man_rd = 1'b0; ovr_clr = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state (R6 R7 R10 R11)
    chk(eoc_flag == 1'b0, "R6 reset eoc", eoc_flag, 0);
    chk(ovr_flag == 1'b0, "R7 reset ovr", ovr_flag, 0);
    chk(data_word == '0, "R11 reset word", data_word, 0);
    chk(dreq == 1'b0, "R10 reset dreq", dreq, 0);

    // R8: start while disabled does nothing
    setup(1, 0, 2, 1, 0, 8'h11);
    cfg_en = 1'b0;
    pulse_start(1'b0);
    send_const(1'b1, 10);
    chk(eoc_flag == 1'b0, "R8 start ignored when disabled", eoc_flag, 0);
    cfg_en = 1'b1;
    send_const(1'b1, 6);
    chk(eoc_flag == 1'b0, "R8 bits ignored while idle", eoc_flag, 0);

    // R4 R8: order 1 pattern, bit during start cycle is not counted
    setup(1, 0, 4, 2, 0, 8'h3C);
    expect_res(4, 9, "R4 order1 pattern");
    pulse_start(1'b1);
    begin
      logic [7:0] p;
      p = 8'b1011_0111;  // bits 1..8 = 1,1,1,0,1,1,0,1
      for (int i = 0; i < 8; i++) send_bit(p[i]);
      send_const(1'b0, 8);
    end
    drain_chk("R8 single returns idle");

    // R2: order 3 and order 5
    setup(3, 0, 64, 2, 0, 8'hA5);
    expect_res(524288, 259, "R2 order3 ones");
    pulse_start(1'b0);
    send_const(1'b1, 262);
    drain_chk("R2 order3");

    setup(5, 0, 8, 1, 0, 8'h05);
    expect_res(-32768, 45, "R2 order5 zeros");
    pulse_start(1'b0);
    send_const(1'b0, 48);
    drain_chk("R2 order5");

    setup(2, 0, 10, 3, 0, 8'h22);
    expect_res(-300, 10 * 4 + 2, "R2 order2 negative");
    pulse_start(1'b0);
    send_const(1'b0, 45);
    drain_chk("R2 order2");

    // R3: fast mode
    setup(4, 1, 16, 4, 0, 8'h7E);
    expect_res(2048, 114, "R3 fast ones");
    pulse_start(1'b0);
    send_const(1'b1, 118);
    drain_chk("R3 fast");

    // R1: ratio limits
    setup(1, 0, 1024, 1, 0, 8'hF0);
    expect_res(1024, 1025, "R1 fosr max");
    pulse_start(1'b0);
    send_const(1'b1, 1028);
    drain_chk("R1 fosr max");

    setup(1, 0, 1, 256, 0, 8'h0F);
    expect_res(-256, 257, "R1 iosr max");
    pulse_start(1'b0);
    send_const(1'b0, 260);
    drain_chk("R1 iosr max");

    // R9: continuous order 1 pattern, period 6
    setup(1, 0, 3, 2, 1, 8'h99);
    for (int j = 0; j < 3; j++) begin
      int s;
      s = 0;
      for (int b = 1; b <= 6; b++) s += pat(j * 6 + b) ? 1 : -1;
      expect_res(s, 7 + j * 6, "R9 continuous pattern");
    end
    pulse_start(1'b0);
    for (int i = 1; i <= 20; i++) send_bit(pat(i));
    @(negedge clk); bit_valid = 1'b0;
    drain_chk("R9 continuous pattern");
    cycle_en();

    setup(2, 0, 4, 1, 1, 8'h44);
    for (int j = 0; j < 3; j++) expect_res(16, 10 + j * 4, "R9 continuous order2");
    pulse_start(1'b0);
    send_const(1'b1, 19);
    drain_chk("R9 continuous order2");
    cycle_en();

    // R7 R6 R10 R11: overrun with reads held off
    mon_on = 1'b0;
    cfg_dreq_en = 1'b1;
    setup(1, 0, 2, 1, 1, 8'h5A);
    pulse_start(1'b0);
    send_const(1'b1, 5);
    chk(eoc_flag == 1'b1, "R6 eoc set", eoc_flag, 1);
    chk(ovr_flag == 1'b1, "R7 overrun set", ovr_flag, 1);
    chk(data_word == {24'd2, 8'h5A}, "R7 newest result kept", data_word, {24'd2, 8'h5A});
    chk(dreq == 1'b1, "R10 dreq follows eoc", dreq, 1);
    @(negedge clk); ovr_clr = 1'b1;
    @(negedge clk); ovr_clr = 1'b0;
    chk(ovr_flag == 1'b0, "R7 overrun cleared", ovr_flag, 0);
    chk(eoc_flag == 1'b1, "R7 clear leaves eoc", eoc_flag, 1);
    @(negedge clk); man_rd = 1'b1;
    @(negedge clk); man_rd = 1'b0;
    chk(eoc_flag == 1'b0, "R6 read clears eoc", eoc_flag, 0);
    chk(dreq == 1'b0, "R10 dreq drops", dreq, 0);
    cfg_dreq_en = 1'b0;
    send_const(1'b1, 2);
    chk(eoc_flag == 1'b1, "R9 next result", eoc_flag, 1);
    chk(dreq == 1'b0, "R10 dreq gated", dreq, 0);
    @(negedge clk); cfg_en = 1'b0;
    @(negedge clk);
    chk(eoc_flag == 1'b0, "R11 disable clears eoc", eoc_flag, 0);
    chk(data_word == '0, "R11 disable clears word", data_word, 0);
    cfg_en = 1'b1;
    mon_on = 1'b1;

    // R11: partial conversion discarded by disable
    setup(1, 0, 4, 1, 0, 8'h66);
    pulse_start(1'b0);
    send_const(1'b0, 3);
    cycle_en();
    expect_res(4, 5, "R11 partial discarded");
    pulse_start(1'b0);
    send_const(1'b1, 6);
    drain_chk("R11 restart");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule